// File: doc/BRIEF.md
# Page Write-Protect Checker

This block guards physical memory against unwanted writes. It keeps two bitmaps of 1024 bits each. One bitmap serves processor cycles and the other serves DMA cycles. Each bit covers one 1K-word page of a 1M-word space. On every bus cycle the block finds the page being touched, reads the bit for that page from the table picked by the DMA acknowledge, and decides whether a memory data write is allowed.

It drives two outputs. The first is an active-low protect-error line. The second is a single line that can work in one of two ways. In write-enable mode it is an active-low enable that follows the data strobe and is given only to legal writes. In flag mode it is an active-high marker of a protection error on a write.

Software loads the bitmaps one bit at a time through a small write port. A separate write port loads a control register, which selects the output mode and turns on physical DMA addressing. In physical DMA addressing, the page of a DMA cycle comes from eight extended-address inputs and two address-state inputs, not from the physical address bus.

Top module: `page_wprot_chk`

## Requirements
- R1: The page index is `phys_addr[19:10]`, so each table holds 1024 pages of 1K words. Address 0x013FF is in page 4 and 0x01400 is in page 5.
- R2: With `dma_ack`=1 the DMA table is consulted; with `dma_ack`=0 the processor table is consulted. A bit set in one table has no effect on cycles that use the other table.
- R3: When physical DMA mode is on and `dma_ack`=1, the page index is `{xadr_in[7:0], aspc_in[1:0]}`, with `xadr_in[7]` as the index MSB, and `phys_addr` is ignored. Processor cycles always use `phys_addr`.
- R4: A memory (`mem_cyc`=1), data (`data_cyc`=1), write (`rd_cyc`=0) cycle to a page whose bit is 1 drives `prot_err_n` low in the same cycle, without waiting for a clock.
- R5: Read cycles, I/O cycles and instruction cycles never drive `prot_err_n` low, whatever the bitmap holds.
- R6: In write-enable mode, `wp_out` is low exactly when `strbd_n`=0 and the cycle is a memory data write with no protection error. In every other case it is high.
- R7: In flag mode, `wp_out` is high exactly when the cycle is a memory data write that hits a protected page, whatever the strobe level. In every other case it is low.
- R8: Reset (`rst_n`=0, asynchronous) clears every bit of both tables and selects write-enable mode with physical DMA mode off.
- R9: When `tbl_we`=1 at a rising clock edge, the bit addressed by `tbl_sel` (0 = processor, 1 = DMA) and `tbl_page` is loaded with `tbl_bit`. The new value is seen only after that edge. Other bits and the other table keep their values.
- R10: When `cfg_we`=1 at a rising clock edge, the control register loads `cfg_flag_mode` (1 = flag mode) and `cfg_phys_dma` (1 = physical DMA mode). The new settings take effect after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_we | input | 1 | Bitmap write strobe |
| tbl_sel | input | 1 | Table to write: 0 processor, 1 DMA |
| tbl_page | input | 10 | Page index to write |
| tbl_bit | input | 1 | Protect value to store |
| cfg_we | input | 1 | Control register write strobe |
| cfg_flag_mode | input | 1 | 1 selects flag mode for `wp_out` |
| cfg_phys_dma | input | 1 | 1 selects physical DMA page addressing |
| phys_addr | input | 20 | Physical word address of the cycle |
| xadr_in | input | 8 | Upper 8 page bits in physical DMA mode |
| aspc_in | input | 2 | Lower 2 page bits in physical DMA mode |
| dma_ack | input | 1 | 1 marks a DMA cycle |
| mem_cyc | input | 1 | 1 memory cycle, 0 I/O cycle |
| data_cyc | input | 1 | 1 data access, 0 instruction access |
| rd_cyc | input | 1 | 1 read, 0 write |
| strbd_n | input | 1 | Data strobe, active low |
| prot_err_n | output | 1 | Protection error, active low |
| wp_out | output | 1 | Write enable (active low) or error flag (active high) |

## Verification
The hardest case to reach from the ports is a DMA cycle in physical mode. Here the page must come only from the extended-address and address-state inputs, and the physical address must carry a different page whose protection is the opposite. The bench first loads the DMA table with a page made from a mixed pattern on those inputs, and protects a second page that a stale physical address would point at. It then enables physical mode through the control port and checks both directions. It also checks that a neighbouring address-state value misses the protected page, which proves that the two inputs sit in the low bits of the index.

// File: rtl/wp_pkg.sv
`timescale 1ns/1ps
package wp_pkg;
  typedef enum logic {
    TBL_CPU = 1'b0,
    TBL_DMA = 1'b1
  } tbl_id_e;

  typedef struct packed {
    logic flag_mode;
    logic phys_dma;
  } wp_cfg_t;
endpackage

// File: rtl/wp_table.sv
`timescale 1ns/1ps
module wp_table #(
  parameter int PAGE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic              wr_val,
  input  logic [PAGE_W-1:0] rd_page,
  output logic              rd_bit
);
  localparam int NPAGES = 1 << PAGE_W;

  logic [NPAGES-1:0] bits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else if (wr_en) bits_q[wr_page] <= wr_val;
  end

  assign rd_bit = bits_q[rd_page];

  // R9
  tbl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> bits_q[$past(wr_page)] == $past(wr_val));

  // R8
  tbl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> bits_q == '0);
endmodule

// File: rtl/wp_ctrl.sv
`timescale 1ns/1ps
module wp_ctrl
  import wp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cfg_we,
  input  logic    cfg_flag_mode,
  input  logic    cfg_phys_dma,
  output wp_cfg_t cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '{flag_mode: 1'b0, phys_dma: 1'b0};
    else if (cfg_we) cfg <= '{flag_mode: cfg_flag_mode, phys_dma: cfg_phys_dma};
  end

  // R10
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg.flag_mode == $past(cfg_flag_mode)) && (cfg.phys_dma == $past(cfg_phys_dma)));

  // R8
  cfg_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !cfg.flag_mode && !cfg.phys_dma);
endmodule

// File: rtl/wp_page_sel.sv
`timescale 1ns/1ps
module wp_page_sel #(
  parameter int ADDR_W = 20,
  parameter int PAGE_W = 10,
  parameter int XA_W   = 8
) (
  input  logic [ADDR_W-1:0]      phys_addr,
  input  logic [XA_W-1:0]        xadr_in,
  input  logic [PAGE_W-XA_W-1:0] aspc_in,
  input  logic                   dma_ack,
  input  logic                   phys_dma,
  output logic [PAGE_W-1:0]      page
);
  localparam int OFS_W = ADDR_W - PAGE_W;
  localparam int AS_W  = PAGE_W - XA_W;

  function automatic logic [PAGE_W-1:0] page_of_addr(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: PAGE_W];
  endfunction

  function automatic logic [PAGE_W-1:0] page_of_ext(input logic [XA_W-1:0] hi,
                                                    input logic [AS_W-1:0] lo);
    return {hi, lo};
  endfunction

  logic unused_ofs;
  assign unused_ofs = ^phys_addr[OFS_W-1:0];

  logic use_ext;
  assign use_ext = dma_ack && phys_dma;
  assign page    = use_ext ? page_of_ext(xadr_in, aspc_in) : page_of_addr(phys_addr);
endmodule

// File: rtl/page_wprot_chk.sv
`timescale 1ns/1ps
module page_wprot_chk
  import wp_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int PAGE_W = 10,
  parameter int XA_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tbl_we,
  input  logic                   tbl_sel,
  input  logic [PAGE_W-1:0]      tbl_page,
  input  logic                   tbl_bit,
  input  logic                   cfg_we,
  input  logic                   cfg_flag_mode,
  input  logic                   cfg_phys_dma,
  input  logic [ADDR_W-1:0]      phys_addr,
  input  logic [XA_W-1:0]        xadr_in,
  input  logic [PAGE_W-XA_W-1:0] aspc_in,
  input  logic                   dma_ack,
  input  logic                   mem_cyc,
  input  logic                   data_cyc,
  input  logic                   rd_cyc,
  input  logic                   strbd_n,
  output logic                   prot_err_n,
  output logic                   wp_out
);
  localparam int NTBL = 2;

  wp_cfg_t          cfg;
  logic [PAGE_W-1:0] cur_page;
  logic [NTBL-1:0]   tbl_hit;
  logic              page_prot;
  logic              mem_data_wr;
  logic              violation;
  logic              legal_wr_strobe;

  wp_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_flag_mode (cfg_flag_mode),
    .cfg_phys_dma  (cfg_phys_dma),
    .cfg           (cfg)
  );

  wp_page_sel #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .XA_W(XA_W)) u_sel (
    .phys_addr (phys_addr),
    .xadr_in   (xadr_in),
    .aspc_in   (aspc_in),
    .dma_ack   (dma_ack),
    .phys_dma  (cfg.phys_dma),
    .page      (cur_page)
  );

  for (genvar t = 0; t < NTBL; t++) begin : g_tbl
    wp_table #(.PAGE_W(PAGE_W)) u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_we && (tbl_sel == t[0])),
      .wr_page (tbl_page),
      .wr_val  (tbl_bit),
      .rd_page (cur_page),
      .rd_bit  (tbl_hit[t])
    );
  end

  assign page_prot       = dma_ack ? tbl_hit[TBL_DMA] : tbl_hit[TBL_CPU];
  assign mem_data_wr     = mem_cyc && data_cyc && !rd_cyc;
  assign violation       = mem_data_wr && page_prot;
  assign legal_wr_strobe = mem_data_wr && !page_prot && !strbd_n;

  assign prot_err_n = !violation;
  assign wp_out     = cfg.flag_mode ? violation : !legal_wr_strobe;

  // R5
  no_err_on_non_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cyc || !mem_cyc || !data_cyc) |-> prot_err_n);

  // R6
  we_mode_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.flag_mode && !wp_out) |-> (prot_err_n && !strbd_n && !rd_cyc));

  // R7
  flag_mode_marks_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.flag_mode |-> (wp_out == !prot_err_n));

  // R4
  err_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_err_n |-> (mem_cyc && data_cyc && !rd_cyc));
endmodule

// File: tb/page_wprot_chk_tb.sv
`timescale 1ns/1ps
module page_wprot_chk_tb_top;
  localparam int CLK_HALF = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 0, tbl_sel = 0, tbl_bit = 0;
  logic [9:0]  tbl_page = '0;
  logic        cfg_we = 0, cfg_flag_mode = 0, cfg_phys_dma = 0;
  logic [19:0] phys_addr = '0;
  logic [7:0]  xadr_in = '0;
  logic [1:0]  aspc_in = '0;
  logic        dma_ack = 0, mem_cyc = 0, data_cyc = 0, rd_cyc = 1, strbd_n = 1;
  logic        prot_err_n, wp_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #CLK_HALF clk = ~clk;

  page_wprot_chk dut_i (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_page(tbl_page),
    .tbl_bit(tbl_bit), .cfg_we(cfg_we), .cfg_flag_mode(cfg_flag_mode),
    .cfg_phys_dma(cfg_phys_dma), .phys_addr(phys_addr), .xadr_in(xadr_in),
    .aspc_in(aspc_in), .dma_ack(dma_ack), .mem_cyc(mem_cyc), .data_cyc(data_cyc),
    .rd_cyc(rd_cyc), .strbd_n(strbd_n), .prot_err_n(prot_err_n), .wp_out(wp_out)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic        flag, phys, dma, mem, dat, rd, stn;
    logic [19:0] addr;
    logic [7:0]  xa;
    logic [1:0]  asp;
    logic        e_err_n, e_wp;
  } vec_t;

  // tables hold: CPU pages 5, 1023; DMA pages 6, 0x2A3
  localparam vec_t VEC [17] = '{
    '{4'd4,  0,0,0,1,1,0,0, 20'h01400, 8'h00, 2'd0, 0,1}, // R4 protected CPU write
    '{4'd1,  0,0,0,1,1,0,0, 20'h013FF, 8'h00, 2'd0, 1,0}, // R1 last word of page 4
    '{4'd2,  0,0,0,1,1,0,0, 20'h01800, 8'h00, 2'd0, 1,0}, // R2 DMA-only page via CPU
    '{4'd2,  0,0,1,1,1,0,0, 20'h01800, 8'h00, 2'd0, 0,1}, // R2 DMA table hit
    '{4'd2,  0,0,1,1,1,0,0, 20'h01400, 8'h00, 2'd0, 1,0}, // R2 CPU-only page via DMA
    '{4'd5,  0,0,0,1,1,1,0, 20'h01400, 8'h00, 2'd0, 1,1}, // R5 read
    '{4'd5,  0,0,0,0,1,0,0, 20'h01400, 8'h00, 2'd0, 1,1}, // R5 I/O write
    '{4'd5,  0,0,0,1,0,0,0, 20'h01400, 8'h00, 2'd0, 1,1}, // R5 instruction cycle
    '{4'd6,  0,0,0,1,1,0,1, 20'h013FF, 8'h00, 2'd0, 1,1}, // R6 strobe idle
    '{4'd1,  0,0,0,1,1,0,0, 20'hFFFFF, 8'h00, 2'd0, 0,1}, // R1 top page
    '{4'd7,  1,0,0,1,1,0,1, 20'h01400, 8'h00, 2'd0, 0,1}, // R7 flag without strobe
    '{4'd7,  1,0,0,1,1,0,0, 20'h013FF, 8'h00, 2'd0, 1,0}, // R7 legal write, flag low
    '{4'd7,  1,0,0,1,1,1,0, 20'h01400, 8'h00, 2'd0, 1,0}, // R7 read, flag low
    '{4'd3,  0,1,1,1,1,0,0, 20'h00000, 8'hA8, 2'd3, 0,1}, // R3 ext page protected
    '{4'd3,  0,1,1,1,1,0,0, 20'h01800, 8'h00, 2'd0, 1,0}, // R3 phys_addr ignored
    '{4'd3,  0,1,0,1,1,0,0, 20'h01400, 8'h00, 2'd0, 0,1}, // R3 CPU keeps phys_addr
    '{4'd3,  0,1,1,1,1,0,0, 20'h00000, 8'hA8, 2'd2, 1,0}  // R3 address-state in LSBs
  };

  task automatic check(input string req, input logic g_err, input logic g_wp,
                       input logic e_err, input logic e_wp);
    checks++;
    if (g_err !== e_err || g_wp !== e_wp) begin
      errors++;
      $display("FAIL %s: prot_err_n=%b wp_out=%b expected prot_err_n=%b wp_out=%b",
               req, g_err, g_wp, e_err, e_wp);
    end
  endtask

  task automatic drive_cycle(input logic dma, input logic mem, input logic dat,
                             input logic rd, input logic stn, input logic [19:0] a);
    dma_ack = dma; mem_cyc = mem; data_cyc = dat; rd_cyc = rd; strbd_n = stn; phys_addr = a;
  endtask

  task automatic load_bit(input logic sel, input logic [9:0] pg, input logic v);
    @(negedge clk);
    tbl_we = 1; tbl_sel = sel; tbl_page = pg; tbl_bit = v;
    @(negedge clk);
    tbl_we = 0;
  endtask

  initial begin
    #(CLK_HALF * 2 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R8 cleared tables, write-enable mode
    drive_cycle(0, 1, 1, 0, 0, 20'h01400);
    #2 check("R8 cpu table clear", prot_err_n, wp_out, 1, 0);
    drive_cycle(1, 1, 1, 0, 0, 20'h01800);
    #2 check("R8 dma table clear", prot_err_n, wp_out, 1, 0);

    load_bit(0, 10'd5, 1);
    load_bit(0, 10'd1023, 1);
    load_bit(1, 10'd6, 1);
    load_bit(1, 10'h2A3, 1);

    // R9 bit only visible after the edge
    @(negedge clk);
    tbl_we = 1; tbl_sel = 0; tbl_page = 10'd7; tbl_bit = 1;
    drive_cycle(0, 1, 1, 0, 0, 20'h01C00);
    #2 check("R9 before edge", prot_err_n, wp_out, 1, 0);
    @(negedge clk);
    tbl_we = 0;
    #2 check("R9 after edge", prot_err_n, wp_out, 0, 1);
    drive_cycle(1, 1, 1, 0, 0, 20'h01C00);
    #2 check("R9 other table untouched", prot_err_n, wp_out, 1, 0);
    load_bit(0, 10'd7, 0);
    drive_cycle(0, 1, 1, 0, 0, 20'h01C00);
    #2 check("R9 bit cleared", prot_err_n, wp_out, 1, 0);
    drive_cycle(0, 1, 1, 0, 0, 20'h01400);
    #2 check("R9 neighbour kept", prot_err_n, wp_out, 0, 1);

    // R10 new mode only after edge
    @(negedge clk);
    cfg_we = 1; cfg_flag_mode = 1; cfg_phys_dma = 0;
    drive_cycle(0, 1, 1, 0, 1, 20'h01400);
    #2 check("R10 before edge", prot_err_n, wp_out, 0, 1);
    @(negedge clk);
    cfg_we = 0;
    drive_cycle(0, 1, 1, 0, 0, 20'h013FF);
    #2 check("R10 after edge", prot_err_n, wp_out, 1, 0);

    for (int i = 0; i < 17; i++) begin
      @(negedge clk);
      cfg_we = 1; cfg_flag_mode = VEC[i].flag; cfg_phys_dma = VEC[i].phys;
      @(negedge clk);
      cfg_we = 0;
      xadr_in = VEC[i].xa; aspc_in = VEC[i].asp;
      drive_cycle(VEC[i].dma, VEC[i].mem, VEC[i].dat, VEC[i].rd, VEC[i].stn, VEC[i].addr);
      #2 check($sformatf("R%0d vector %0d", VEC[i].rq, i), prot_err_n, wp_out,
               VEC[i].e_err_n, VEC[i].e_wp);
    end

    // R8 mid-run reset clears bitmap and mode
    @(negedge clk);
    cfg_we = 1; cfg_flag_mode = 1; cfg_phys_dma = 1;
    @(negedge clk);
    cfg_we = 0;
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    xadr_in = 8'hA8; aspc_in = 2'd3;
    drive_cycle(0, 1, 1, 0, 0, 20'h01400);
    #2 check("R8 reset clears cpu bit, WE mode", prot_err_n, wp_out, 1, 0);
    drive_cycle(1, 1, 1, 0, 0, 20'h01800);
    #2 check("R8 reset clears phys mode and dma bit", prot_err_n, wp_out, 1, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule